// File: doc/BRIEF.md
# Stuck-at Coverage Monitor for Reversible Cascades

This block watches a reversible gate cascade while a test set is applied to it. Each time a test vector goes in, the cascade evaluator hands over the values on all wires at every level as one flat vector. For every level and wire the monitor keeps two sticky flags. One records that the site has carried a 0. The other records that it has carried a 1.

A site never seen at 0 hides its stuck-at-1 fault, and a site never seen at 1 hides its stuck-at-0 fault. The block counts, for each polarity, the sites that are still uncovered. It raises a completion flag once every active site has carried both values. The circuit is reversible, so every internal change reaches the outputs. Seeing both values at every site is therefore both necessary and sufficient for single-fault coverage, and single-fault coverage also covers every combination of multiple stuck-at faults. No extra tracking is needed for multiple faults.

The user chooses the circuit depth at run time. Levels deeper than that depth do not take part in the decision. A synchronous clear starts a new test set.

Top module: `stuck_cover_mon`

## Requirements
- R1: After reset no site has been seen at either value. Both uncovered counts equal the number of active sites, and `complete_o` is 0.
- R2: On a clock edge with `vld_i` high and `clr_i` low, each site whose bit is 0 becomes seen-at-0 and each site whose bit is 1 becomes seen-at-1. The counts and flag show this right after that edge.
- R3: Recorded coverage is sticky. Without `vld_i` or `clr_i`, a change of `lvl_vec_i` leaves the outputs unchanged, and an uncovered count never rises while depth is constant.
- R4: `clr_i` is synchronous and forgets all coverage at the next edge. It wins over a `vld_i` in the same cycle, and the vector of that cycle is dropped.
- R5: `complete_o` is 1 exactly when both uncovered counts are zero, that is, when every active site has been seen at 0 and at 1.
- R6: `zero_miss_o` counts active sites never seen at 0 (stuck-at-1 not yet detectable). `one_miss_o` counts active sites never seen at 1 (stuck-at-0 not yet detectable). Neither exceeds the number of active sites.
- R7: Level l is active when l <= `depth_i`. A `depth_i` of NLVL-1 or more makes all levels active. Changing the depth alters the outputs at once and discards no recorded coverage.
- R8: Bit l*NWIRE + w of `lvl_vec_i` is wire w at level l, with level 0 being the cascade inputs.
- R9: For a cascade of controlled-NOT gates only, the all-zeros input together with the NWIRE weight-one inputs leaves the block complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear pulse, starts a new test set |
| vld_i | input | 1 | Level vector strobe |
| lvl_vec_i | input | NLVL*NWIRE | Wire values of all levels for one applied vector |
| depth_i | input | LW | Deepest level that takes part in the decision |
| complete_o | output | 1 | Every active site seen at both 0 and 1 |
| zero_miss_o | output | CW | Active sites never seen at 0 |
| one_miss_o | output | CW | Active sites never seen at 1 |

## Verification
The assertions take for granted that `clr_i` is low while reset is applied. They also assume `depth_i` holds a defined value from reset onward, since their history terms compare the depth between cycles. The stimulus drives every input to a known value before reset is released and keeps `clr_i` low during reset. It changes inputs only just after the falling clock edge. Depth is changed only in cycles the bench marks as depth tests, so the sticky and monotone properties are checked over stretches where depth is constant.

// File: rtl/sc_pkg.sv
// Shared sizing helpers for the stuck-at coverage monitor.
// Assumes: callers pass positive counts.
package sc_pkg;
    // Width needed to hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Width of an index selecting one of n items (at least one bit)
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sc_level_track.sv
// Sticky seen-at-0 / seen-at-1 flags for the wires of one cascade level.
// Assumes: clr_i and vld_i are synchronous to clk, and clr_i wins over vld_i.
module sc_level_track #(
    parameter int NWIRE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic [NWIRE-1:0] wires_i,
    output logic [NWIRE-1:0] seen0_o,
    output logic [NWIRE-1:0] seen1_o
);
    // Accumulate the observed polarity of each wire on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            seen0_o <= '0;
            seen1_o <= '0;
        end else if (vld_i) begin
            seen0_o <= seen0_o | ~wires_i;
            seen1_o <= seen1_o |  wires_i;
        end
    end
endmodule

// File: rtl/sc_popcount.sv
// Combinational count of set bits in a vector.
// Assumes: CW is wide enough to hold N.
module sc_popcount #(
    parameter int N  = 24,
    parameter int CW = 5
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    // Add up the ones bit by bit
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + CW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/stuck_cover_mon.sv
// Stuck-at coverage monitor: tracks, per level and wire, whether each site
// has been seen at 0 and at 1 across the applied test set, and reports the
// uncovered counts per polarity and a completion flag.
// Assumes: the observed circuit is reversible, so per-site 0/1 observation
// decides single and multiple stuck-at coverage. Level l occupies bits
// [l*NWIRE +: NWIRE] of lvl_vec_i.
module stuck_cover_mon #(
    parameter int NWIRE = 4,
    parameter int NLVL  = 6,
    parameter int NSITE = NWIRE * NLVL,
    parameter int LW    = sc_pkg::idx_width(NLVL),
    parameter int CW    = sc_pkg::cnt_width(NWIRE * NLVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic [NSITE-1:0] lvl_vec_i,
    input  logic [LW-1:0]    depth_i,
    output logic             complete_o,
    output logic [CW-1:0]    zero_miss_o,
    output logic [CW-1:0]    one_miss_o
);
    logic [NSITE-1:0] seen0;
    logic [NSITE-1:0] seen1;
    logic [NSITE-1:0] site_on;
    logic [NSITE-1:0] miss0;
    logic [NSITE-1:0] miss1;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        localparam logic [LW-1:0] LIDX = LW'(l);

        sc_level_track #(.NWIRE(NWIRE)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_i),
            .vld_i   (vld_i),
            .wires_i (lvl_vec_i[l*NWIRE +: NWIRE]),
            .seen0_o (seen0[l*NWIRE +: NWIRE]),
            .seen1_o (seen1[l*NWIRE +: NWIRE])
        );

        // Enable the sites of this level when it lies within the depth
        assign site_on[l*NWIRE +: NWIRE] = {NWIRE{LIDX <= depth_i}};
    end

    // Sites still missing each polarity, restricted to active levels
    assign miss0 = ~seen0 & site_on;
    assign miss1 = ~seen1 & site_on;

    sc_popcount #(.N(NSITE), .CW(CW)) u_cnt0 (
        .bits_i  (miss0),
        .count_o (zero_miss_o)
    );

    sc_popcount #(.N(NSITE), .CW(CW)) u_cnt1 (
        .bits_i  (miss1),
        .count_o (one_miss_o)
    );

    // Complete when no active site lacks either polarity
    assign complete_o = ~|(miss0 | miss1);
endmodule

// File: rtl/stuck_cover_mon_chk.sv
// Property checker for stuck_cover_mon, bound to every instance.
// Assumes: clr_i is low during reset and depth_i is defined from reset on.
module stuck_cover_mon_chk #(
    parameter int NWIRE = 4,
    parameter int NLVL  = 6,
    parameter int LW    = 3,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_i,
    input logic          vld_i,
    input logic [LW-1:0] depth_i,
    input logic          complete_o,
    input logic [CW-1:0] zero_miss_o,
    input logic [CW-1:0] one_miss_o
);
    int n_act;

    // Number of sites currently taking part in the decision
    always_comb begin
        n_act = ((int'(depth_i) >= NLVL) ? NLVL : int'(depth_i) + 1) * NWIRE;
    end

    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (!complete_o && zero_miss_o == one_miss_o && int'(zero_miss_o) == n_act));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_i) && !$past(vld_i) && $stable(depth_i)) |-> ($stable(zero_miss_o) && $stable(one_miss_o)));

    // R3
    miss_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_i) && $stable(depth_i)) |-> (zero_miss_o <= $past(zero_miss_o) && one_miss_o <= $past(one_miss_o)));

    // R5
    done_means_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete_o |-> (zero_miss_o == '0 && one_miss_o == '0));

    // R5
    none_means_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_miss_o == '0 && one_miss_o == '0) |-> complete_o);

    // R6
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(zero_miss_o) <= n_act && int'(one_miss_o) <= n_act));
endmodule

bind stuck_cover_mon stuck_cover_mon_chk #(
    .NWIRE (NWIRE),
    .NLVL  (NLVL),
    .LW    (LW),
    .CW    (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .vld_i       (vld_i),
    .depth_i     (depth_i),
    .complete_o  (complete_o),
    .zero_miss_o (zero_miss_o),
    .one_miss_o  (one_miss_o)
);

// File: tb/tb_stuck_cover_mon.sv
module tb_stuck_cover_mon;
    localparam int CLK_P = 10;
    localparam int NW    = 4;
    localparam int NL    = 6;
    localparam int NS    = NW * NL;

    typedef struct {
        logic  cpl;
        int    m0;
        int    m1;
        string tag;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          clr_i = 0;
    logic          vld_i = 0;
    logic [NS-1:0] lvl_vec_i = '0;
    logic [2:0]    depth_i = 3'd5;
    logic          complete_o;
    logic [4:0]    zero_miss_o;
    logic [4:0]    one_miss_o;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];
    bit   s0 [NL][NW];
    bit   s1 [NL][NW];

    stuck_cover_mon #(.NWIRE(NW), .NLVL(NL)) dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_i(vld_i),
        .lvl_vec_i(lvl_vec_i), .depth_i(depth_i), .complete_o(complete_o),
        .zero_miss_o(zero_miss_o), .one_miss_o(one_miss_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Controlled-NOT cascade: level values for one input word (R8 layout)
    function automatic logic [NS-1:0] casc(input logic [NW-1:0] x);
        logic [NW-1:0] w;
        logic [NS-1:0] r;
        w = x;      r[3:0]   = w;
        w[1] ^= w[0]; r[7:4]   = w;
        w[3] ^= w[1]; r[11:8]  = w;
        w[0] ^= w[2]; r[15:12] = w;
        w[2] ^= w[3]; r[19:16] = w;
        w[1] ^= w[2]; r[23:20] = w;
        return r;
    endfunction

    // Driver: apply one cycle of stimulus, update model, queue expectation
    task automatic step(input logic c, input logic v, input logic [NS-1:0] vec,
                        input logic [2:0] d, input string tag);
        exp_t e;
        int   dl;
        @(negedge clk); #1;
        clr_i = c; vld_i = v; lvl_vec_i = vec; depth_i = d;
        for (int l = 0; l < NL; l++) begin
            for (int w = 0; w < NW; w++) begin
                if (c) begin
                    s0[l][w] = 0; s1[l][w] = 0;
                end else if (v) begin
                    if (vec[l*NW + w]) s1[l][w] = 1; else s0[l][w] = 1;
                end
            end
        end
        dl = (int'(d) >= NL) ? NL - 1 : int'(d);
        e.m0 = 0; e.m1 = 0;
        for (int l = 0; l <= dl; l++) begin
            for (int w = 0; w < NW; w++) begin
                if (!s0[l][w]) e.m0++;
                if (!s1[l][w]) e.m1++;
            end
        end
        e.cpl = (e.m0 == 0) && (e.m1 == 0);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare outputs against the oldest expectation
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (complete_o !== e.cpl || int'(zero_miss_o) != e.m0 || int'(one_miss_o) != e.m1) begin
                n_bad++;
                $display("FAIL %s: got cpl=%0d m0=%0d m1=%0d exp cpl=%0d m0=%0d m1=%0d",
                         e.tag, complete_o, zero_miss_o, one_miss_o, e.cpl, e.m0, e.m1);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: got hang exp finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        step(0, 0, '0, 3'd5, "R1 reset state");
        step(0, 1, '0, 3'd5, "R2 all-zero vector");
        step(0, 0, '1, 3'd5, "R3 vector ignored without strobe");
        step(0, 1, '1, 3'd5, "R5 all-ones completes");
        step(1, 1, '0, 3'd5, "R4 clear wins over strobe");
        step(0, 1, 24'h00000A, 3'd0, "R7 depth 0 partial");
        step(0, 1, 24'hFFFFF5, 3'd0, "R7 depth 0 complete");
        step(0, 0, '0, 3'd5, "R7 deeper depth keeps state");
        step(0, 0, '0, 3'd7, "R7 out-of-range depth");
        step(1, 0, '0, 3'd5, "R4 clear");
        step(0, 1, 24'h000800, 3'd5, "R8 single site level2 wire3");
        step(1, 0, '0, 3'd5, "R4 clear before cascade");
        step(0, 1, casc(4'b0000), 3'd5, "R9 cascade zero");
        step(0, 1, casc(4'b0001), 3'd5, "R9 cascade w0");
        step(0, 1, casc(4'b0010), 3'd5, "R9 cascade w1");
        step(0, 1, casc(4'b0100), 3'd5, "R9 cascade w2");
        step(0, 1, casc(4'b1000), 3'd5, "R9 cascade w3");
        step(0, 0, '0, 3'd5, "R6 idle after cascade");
        @(negedge clk);
        n_chk++;
        if (complete_o !== 1'b1) begin
            n_bad++;
            $display("FAIL R9: got complete=%0d exp 1", complete_o);
        end
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule